// File: doc/BRIEF.md
# Video and Graphics Keying Mixer

This block merges a live video stream (an 8-bit luma sample and an 8-bit multiplexed chroma sample per pixel) with a graphics stream. For every pixel it decides which of the two sources reaches the output. Graphics pixels enter as a 4-bit palette index. The matching luma/chroma colour comes back from an external colour lookup table one cycle later. A 2-bit mode input selects the rule used to pick a source.

With an external key, a per-pixel key input chooses the source. With a chroma key, graphics form the front layer. Video shows through wherever the graphics index equals a programmable transparent index. The two remaining mode values pass video only. The key, the index and the mode are delayed by one cycle inside the block, so the decision meets the lookup colour and the video sample of the same pixel. The chosen luma and chroma are then registered together.

Top module: `keymix_top`

## Requirements
- R1: While `rstN` is low, `outY`, `outC` and `outGfx` are zero.
- R2: Mode values 0 and 1 select video for every pixel, whatever the key and index inputs are.
- R3: Mode value 3 (external key) with `keyIn` high selects the lookup colour for that pixel.
- R4: Mode value 3 with `keyIn` low selects the video pixel.
- R5: Mode value 2 (chroma key) selects video for a pixel whose `gfxIdx` equals the transparent index.
- R6: Mode value 2 selects the lookup colour for a pixel whose `gfxIdx` differs from the transparent index.
- R7: `modeSel`, `keyIn` and `gfxIdx` sampled at clock edge n pair with `vidY`/`vidC`/`lutY`/`lutC` sampled at edge n+1. The result appears after edge n+1. The source may change on every pixel.
- R8: The transparent index resets to 0 and loads `transData` at an edge where `transWe` is high. Otherwise it holds its value. An index sampled at the same edge as a write is compared against the old value.
- R9: `outY` and `outC` always come from the same source in the same cycle. `outGfx` is 1 when that source is graphics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | Combine rule: 0/1 video, 2 chroma key, 3 external key |
| keyIn | input | 1 | Per-pixel external key, aligned with gfxIdx |
| gfxIdx | input | 4 | Graphics palette index of the current pixel |
| transWe | input | 1 | Load strobe for the transparent index |
| transData | input | 4 | New transparent index value |
| vidY | input | 8 | Video luma, one cycle after its pixel's index |
| vidC | input | 8 | Video multiplexed chroma, same timing as vidY |
| lutY | input | 8 | Lookup-table luma for the index of the previous cycle |
| lutC | input | 8 | Lookup-table chroma for the index of the previous cycle |
| outY | output | 8 | Mixed luma |
| outC | output | 8 | Mixed chroma |
| outGfx | output | 1 | 1 when the current output pixel came from graphics |

## Verification
A write to the transparent index can fall on the same edge at which a chroma-key pixel's index is sampled. The bench provokes this by streaming pixels in chroma-key mode and issuing writes in the middle of the stream, both directed and at random. Some of these writes switch the transparent index to, or away from, the index being presented. The bench's reference model compares every sampled index against the value held before the edge, and then applies the write. A design that compares against the new value picks the wrong source for exactly those pixels.

// File: rtl/keymix_pkg.sv
package keymix_pkg;

  typedef enum logic [1:0] {
    MIX_VIDEO_A = 2'b00,
    MIX_VIDEO_B = 2'b01,
    MIX_CHROMA  = 2'b10,
    MIX_EXTKEY  = 2'b11
  } mixMode_e;

  // strobes from the decision stage to the output datapath
  typedef struct packed {
    logic selGfx;   // take lookup colour instead of video
  } mixStrobe_t;

endpackage

// File: rtl/keymix_ctrl.sv
module keymix_ctrl
  import keymix_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             keyIn,
  input  logic [IDX_W-1:0] gfxIdx,
  input  logic             transWe,
  input  logic [IDX_W-1:0] transData,
  output mixStrobe_t       strobe
);

  logic [IDX_W-1:0] transReg;
  mixMode_e         modeD;
  logic             keyD;
  logic             hitD;
  logic             seenEdge;

  // transparent index register: compare below sees the pre-write value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      transReg <= '0;
    end else if (transWe) begin
      transReg <= transData;
    end
  end

  // align per-pixel controls with the one-cycle lookup latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeD <= MIX_VIDEO_A;
      keyD  <= 1'b0;
      hitD  <= 1'b0;
    end else begin
      modeD <= mixMode_e'(modeSel);
      keyD  <= keyIn;
      hitD  <= (gfxIdx == transReg);
    end
  end

  always_comb begin
    strobe = '0;
    unique case (modeD)
      MIX_EXTKEY:  strobe.selGfx = keyD;
      MIX_CHROMA:  strobe.selGfx = !hitD;
      default:     strobe.selGfx = 1'b0;
    endcase
  end

  // assertion support: one edge out of reset seen
  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assert_video_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !$past(modeSel[1])) |-> !strobe.selGfx);

  assert_key_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && $past(modeSel) == 2'b11 && $past(keyIn)) |-> strobe.selGfx);

  assert_key_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && $past(modeSel) == 2'b11 && !$past(keyIn)) |-> !strobe.selGfx);

  assert_chroma_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && $past(modeSel) == 2'b10) |->
      (strobe.selGfx == ($past(gfxIdx) != $past(transReg))));

  assert_trans_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !$past(transWe)) |-> $stable(transReg));

endmodule

// File: rtl/keymix_dpath.sv
module keymix_dpath
  import keymix_pkg::*;
#(
  parameter int Y_W = 8,
  parameter int C_W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  mixStrobe_t     strobe,
  input  logic [Y_W-1:0] vidY,
  input  logic [C_W-1:0] vidC,
  input  logic [Y_W-1:0] lutY,
  input  logic [C_W-1:0] lutC,
  output logic [Y_W-1:0] outY,
  output logic [C_W-1:0] outC,
  output logic           outGfx
);

  localparam int PIX_W = Y_W + C_W;

  logic [PIX_W-1:0] vidPix;
  logic [PIX_W-1:0] gfxPix;
  logic [PIX_W-1:0] pickPix;
  logic             seenEdge;

  // one mux over the packed pair keeps luma and chroma on one select
  assign vidPix  = {vidY, vidC};
  assign gfxPix  = {lutY, lutC};
  assign pickPix = strobe.selGfx ? gfxPix : vidPix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outY   <= '0;
      outC   <= '0;
      outGfx <= 1'b0;
    end else begin
      outY   <= pickPix[PIX_W-1:C_W];
      outC   <= pickPix[C_W-1:0];
      outGfx <= strobe.selGfx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  assert_pair_gfx_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && outGfx) |-> (outY == $past(lutY) && outC == $past(lutC)));

  assert_pair_vid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !outGfx) |-> (outY == $past(vidY) && outC == $past(vidC)));

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge |-> (outGfx == $past(strobe.selGfx)));

endmodule

// File: rtl/keymix_top.sv
module keymix_top
  import keymix_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int Y_W   = 8,
  parameter int C_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             keyIn,
  input  logic [IDX_W-1:0] gfxIdx,
  input  logic             transWe,
  input  logic [IDX_W-1:0] transData,
  input  logic [Y_W-1:0]   vidY,
  input  logic [C_W-1:0]   vidC,
  input  logic [Y_W-1:0]   lutY,
  input  logic [C_W-1:0]   lutC,
  output logic [Y_W-1:0]   outY,
  output logic [C_W-1:0]   outC,
  output logic             outGfx
);

  mixStrobe_t strobe;

  keymix_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .keyIn     (keyIn),
    .gfxIdx    (gfxIdx),
    .transWe   (transWe),
    .transData (transData),
    .strobe    (strobe)
  );

  keymix_dpath #(.Y_W(Y_W), .C_W(C_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .vidY   (vidY),
    .vidC   (vidC),
    .lutY   (lutY),
    .lutC   (lutC),
    .outY   (outY),
    .outC   (outC),
    .outGfx (outGfx)
  );

endmodule

// File: tb/sim_keymix_top.sv
`timescale 1ns/1ps
module sim_keymix_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = '0;
  logic       keyIn = 1'b0;
  logic [3:0] gfxIdx = '0;
  logic       transWe = 1'b0;
  logic [3:0] transData = '0;
  logic [7:0] vidY = '0, vidC = '0, lutY = '0, lutC = '0;
  logic [7:0] outY, outC;
  logic       outGfx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  keymix_top u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .keyIn(keyIn), .gfxIdx(gfxIdx),
    .transWe(transWe), .transData(transData), .vidY(vidY), .vidC(vidC),
    .lutY(lutY), .lutC(lutC), .outY(outY), .outC(outC), .outGfx(outGfx)
  );

  // reference state
  logic [3:0] refTrans;
  logic [1:0] m1Mode, m2Mode;
  logic       m1Key, m2Key, m1Hit, m2Hit;
  logic [7:0] d1VY, d1VC, d1LY, d1LC;
  int         live;

  function automatic logic refSel(input logic [1:0] m, input logic k, input logic h);
    if (m == 2'b11) return k;
    if (m == 2'b10) return !h;
    return 1'b0;
  endfunction

  function automatic string refTag(input logic [1:0] m, input logic k, input logic h);
    if (m[1] == 1'b0) return "R2";
    if (m == 2'b11) return k ? "R3" : "R4";
    return h ? "R5" : "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one pixel at the falling edge, checking the output first
  task automatic pixel(input string forced, input logic [1:0] m, input logic k,
                       input logic [3:0] idx, input logic we, input logic [3:0] wd);
    logic [7:0] vy, vc, ly, lc;
    logic s;
    string t;
    @(negedge clk);
    if (live >= 2) begin
      s = refSel(m2Mode, m2Key, m2Hit);
      t = (forced != "") ? forced : refTag(m2Mode, m2Key, m2Hit);
      check(t, {31'd0, outGfx}, {31'd0, s});
      check({t, "/R9"}, {16'd0, outY, outC}, s ? {16'd0, d1LY, d1LC} : {16'd0, d1VY, d1VC});
    end
    vy = 8'($urandom); vc = 8'($urandom); ly = 8'($urandom); lc = 8'($urandom);
    modeSel = m; keyIn = k; gfxIdx = idx; transWe = we; transData = wd;
    vidY = vy; vidC = vc; lutY = ly; lutC = lc;
    m2Mode = m1Mode; m2Key = m1Key; m2Hit = m1Hit;
    m1Mode = m; m1Key = k; m1Hit = (idx == refTrans);   // old value, R8
    if (we) refTrans = wd;
    d1VY = vy; d1VC = vc; d1LY = ly; d1LC = lc;
    if (live < 2) live++;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2210));
    refTrans = '0; live = 0;
    m1Mode = '0; m2Mode = '0; m1Key = 0; m2Key = 0; m1Hit = 0; m2Hit = 0;
    d1VY = '0; d1VC = '0; d1LY = '0; d1LC = '0;
    // R1: reset with aggressive inputs
    modeSel = 2'b11; keyIn = 1'b1; vidY = 8'hAA; lutY = 8'h55; lutC = 8'h33;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {16'd0, outY, outC}, 32'd0);
    check("R1", {31'd0, outGfx}, 32'd0);
    rstN = 1'b1;

    // R2: video-only modes with key high and non-transparent index
    for (int i = 0; i < 8; i++) pixel("", 2'(i % 2), 1'b1, 4'hF, 1'b0, 4'h0);
    // R7: key toggles on every pixel in external key mode
    for (int i = 0; i < 10; i++) pixel(i >= 2 ? "R7" : "", 2'b11, 1'(i % 2), 4'h0, 1'b0, 4'h0);
    // R3/R4 directed runs
    for (int i = 0; i < 4; i++) pixel("", 2'b11, 1'b1, 4'h7, 1'b0, 4'h0);
    for (int i = 0; i < 4; i++) pixel("", 2'b11, 1'b0, 4'h7, 1'b0, 4'h0);
    // R5/R6 against reset transparent value 0
    for (int i = 0; i < 6; i++) pixel("", 2'b10, 1'b0, 4'(i % 3), 1'b0, 4'h0);
    // R8: write collides with a sampled index equal to the new value
    pixel("", 2'b10, 1'b0, 4'h9, 1'b1, 4'h9);
    pixel("", 2'b10, 1'b0, 4'h9, 1'b0, 4'h0);
    pixel("", 2'b10, 1'b0, 4'h9, 1'b1, 4'h4);
    pixel("", 2'b10, 1'b0, 4'h4, 1'b0, 4'h0);
    pixel("", 2'b10, 1'b0, 4'h9, 1'b0, 4'h0);
    pixel("R8", 2'b10, 1'b0, 4'h4, 1'b0, 4'h0);
    pixel("R8", 2'b10, 1'b0, 4'h9, 1'b0, 4'h0);
    pixel("R8", 2'b10, 1'b0, 4'h4, 1'b0, 4'h0);
    pixel("R8", 2'b10, 1'b0, 4'h0, 1'b0, 4'h0);

    // random mix, index biased toward the transparent value
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] idx;
      idx = ($urandom % 3 == 0) ? refTrans : 4'($urandom);
      pixel("", 2'($urandom), 1'($urandom), idx, ($urandom % 8 == 0), 4'($urandom % 4));
    end
    pixel("", 2'b00, 1'b0, 4'h0, 1'b0, 4'h0);
    pixel("", 2'b00, 1'b0, 4'h0, 1'b0, 4'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule